// File: doc/BRIEF.md
# Receive Packet FIFO with Head Status Word

This block is the receive-side buffer of a simple Ethernet controller. Bytes of incoming frames arrive from the MAC side, one per cycle, marked with start-of-frame and end-of-frame strobes. The start byte carries a destination class and the end byte carries a 4-bit error code. A per-class accept mask decides whether a frame is kept at all. Accepted frames are written into a byte store. Each finished frame leaves a descriptor (byte count plus error code) in a queue of at most eight packets.

The host sees only the oldest packet. A combinational 16-bit status word reports whether a complete packet is at the head, its error class, and how many of its bytes remain unread. The host pulls the packet out as 16-bit words, low byte first, and then issues a discard that drops whatever is left of the packet and exposes the next one. Three conditions are flagged:
- storage overrun, when bytes arrive with the byte store full;
- status overrun, when a ninth packet is offered;
- underrun, when the host reads past the end of the data and raises adapter failure.

A receive-reset strobe empties the block.

Top module: `rx_pkt_fifo`

## Requirements
- R1: `status_word` bit 15 is 1 when no complete packet is queued. In that case bits 14:0 are zero, except that bits 10:0 show the bytes stored so far of a frame still being received. With a complete packet at the head, bit 15 is 0, bits 14:11 hold its error code and bits 10:0 hold its unread byte count. After reset `status_word` is 16'h8000.
- R2: The error code on `in_err` with the end byte is stored with the packet and shown in bits 14:11. Bit 14 set means error. For example 4'b1101 (CRC) gives 16'h6800 plus the count, and 4'b0010 (dribble, no error) gives 16'h1000 plus the count.
- R3: While `rd_word` is high, `rd_data` holds the next unread byte of the head packet in bits 7:0 and the byte after it in bits 15:8. The clock edge consumes two bytes. When only one byte remains, bits 15:8 are the pad byte 8'h00 and one byte is consumed.
- R4: `discard` drops the rest of the head packet, and the next packet's status appears in the following cycle. With no complete packet queued, `discard` has no effect. `discard` takes priority over `rd_word` in the same cycle.
- R5: At most 8 complete packets are queued. An accepted-class frame that starts while 8 are queued is refused and sets `stat_ovr_flag`. The flag clears on the next `discard` that removes a packet.
- R6: A frame byte that arrives while all storage bytes are in use sets `ovr_flag`. Such a byte and the rest of its frame are dropped, and the frame is queued with the bytes already stored and error code 4'b1000. Frames that start while `ovr_flag` is set or storage is full are refused. `ovr_flag` clears when a word read or a discard frees bytes.
- R7: A `rd_word` without a complete packet at the head, or with zero unread bytes, sets `underrun_flag` and `adapter_fail`. Nothing is consumed. Both flags stay set until `rx_reset` or `rst_n`.
- R8: `filt_mask` bit 0 accepts class 0 (own station), bit 1 accepts class 1 (multicast), bit 2 accepts class 2 (broadcast), and bit 3 accepts every class including class 3 (other station).
- R9: `rx_complete` is high exactly while at least one complete packet is queued.
- R10: `rx_reset` empties the FIFO, drops any frame in progress, and clears `ovr_flag`, `stat_ovr_flag` and `underrun_flag`.
- R11: A frame refused by the filter changes neither `status_word` nor `rx_complete`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_reset | input | 1 | Synchronous receive reset strobe |
| filt_mask | input | 4 | Accept mask by destination class |
| in_valid | input | 1 | Byte valid from MAC side |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| in_class | input | 2 | Destination class, sampled with the first byte |
| in_err | input | 4 | Error code, sampled with the last byte |
| rd_word | input | 1 | Consume one word of the head packet |
| discard | input | 1 | Drop the remainder of the head packet |
| rd_data | output | 16 | Next word of the head packet |
| status_word | output | 16 | Head status word |
| rx_complete | output | 1 | At least one complete packet queued |
| ovr_flag | output | 1 | Byte storage overrun |
| stat_ovr_flag | output | 1 | Packet count overrun |
| underrun_flag | output | 1 | Read past end of packet |
| adapter_fail | output | 1 | Adapter failure indication |

## Verification
The hardest state to reach from the ports is a full byte store in the middle of a frame. It needs a large accepted frame already queued and a second frame long enough to cross the last free byte. A directed sequence sends a 200-byte frame and then a 100-byte frame into the 256-byte store, so the truncation point falls exactly at byte 56. A third frame then checks refusal, and a single word read checks that the flag clears. A second directed sequence queues eight packets and offers a ninth to reach the status limit. Random rounds with random masks, classes, error codes and lengths cover ordinary traffic, and each round is drained word by word against a bench model.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int unsigned LEN_W     = 11;
   localparam int unsigned MAX_FRAME = 1514;

   typedef logic [3:0] err_code_t;
   localparam err_code_t ERR_NONE    = 4'b0000;
   localparam err_code_t ERR_OVERRUN = 4'b1000;

   typedef enum logic [1:0] {
      CLS_STATION = 2'd0,
      CLS_MULTI   = 2'd1,
      CLS_BCAST   = 2'd2,
      CLS_OTHER   = 2'd3
   } dest_class_t;

   typedef struct packed {
      err_code_t        code;
      logic [LEN_W-1:0] len;
   } pkt_desc_t;

   localparam int unsigned DESC_W = $bits(pkt_desc_t);
endpackage

// File: rtl/rxq_class_filter.sv
module rxq_class_filter
   import rxq_pkg::*;
(
   input  logic [3:0]  accept_mask,
   input  dest_class_t cls,
   output logic        pass
);
   always_comb begin
      unique case (cls)
         CLS_STATION: pass = accept_mask[0] | accept_mask[3];
         CLS_MULTI:   pass = accept_mask[1] | accept_mask[3];
         CLS_BCAST:   pass = accept_mask[2] | accept_mask[3];
         default:     pass = accept_mask[3];
      endcase
   end
endmodule

// File: rtl/rxq_byte_store.sv
module rxq_byte_store #(
   parameter int unsigned DEPTH = 256,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          wr_en,
   input  logic [7:0]    wr_data,
   input  logic [AW:0]   rd_adv,
   output logic [7:0]    rd_lo,
   output logic [7:0]    rd_hi,
   output logic [AW:0]   used
);
   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, rd_ptr_nx;

   assign rd_ptr_nx = rd_ptr + AW'(1);
   assign rd_lo     = mem[rd_ptr];
   assign rd_hi     = mem[rd_ptr_nx];

   always_ff @(posedge clk) begin
      if (wr_en && !flush) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         used   <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         used   <= '0;
      end else begin
         if (wr_en) wr_ptr <= wr_ptr + AW'(1);
         rd_ptr <= rd_ptr + rd_adv[AW-1:0];
         used   <= used + (AW+1)'(wr_en) - rd_adv;
      end
   end
endmodule

// File: rtl/rxq_desc_queue.sv
module rxq_desc_queue #(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned W       = 15,
   localparam int unsigned IW     = $clog2(ENTRIES),
   localparam int unsigned CW     = $clog2(ENTRIES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic [CW-1:0] count
);
   localparam logic [IW-1:0] LAST_IDX = IW'(ENTRIES - 1);

   logic [W-1:0]  slot [ENTRIES];
   logic [IW-1:0] wr_idx, rd_idx;

   function automatic logic [IW-1:0] bump(input logic [IW-1:0] idx);
      return (idx == LAST_IDX) ? '0 : idx + IW'(1);
   endfunction

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (push && !flush && wr_idx == IW'(g)) slot[g] <= push_data;
      end
   end

   assign head = slot[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_idx <= '0;
         rd_idx <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_idx <= '0;
         rd_idx <= '0;
         count  <= '0;
      end else begin
         if (push) wr_idx <= bump(wr_idx);
         if (pop)  rd_idx <= bump(rd_idx);
         count <= count + CW'(push) - CW'(pop);
      end
   end
endmodule

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo
   import rxq_pkg::*;
#(
   parameter int unsigned BYTE_DEPTH = 256,
   parameter int unsigned MAX_PKTS   = 8,
   parameter bit          PAD_REPEAT = 1'b0,
   parameter logic [7:0]  PAD_BYTE   = 8'h00
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rx_reset,
   input  logic [3:0]  filt_mask,
   input  logic        in_valid,
   input  logic        in_sof,
   input  logic        in_eof,
   input  logic [7:0]  in_data,
   input  logic [1:0]  in_class,
   input  logic [3:0]  in_err,
   input  logic        rd_word,
   input  logic        discard,
   output logic [15:0] rd_data,
   output logic [15:0] status_word,
   output logic        rx_complete,
   output logic        ovr_flag,
   output logic        stat_ovr_flag,
   output logic        underrun_flag,
   output logic        adapter_fail
);
   localparam int unsigned AW = $clog2(BYTE_DEPTH);
   localparam int unsigned CW = $clog2(MAX_PKTS + 1);
   localparam logic [CW-1:0]  PKT_LIMIT = CW'(MAX_PKTS);
   localparam logic [AW:0]    STORE_TOP = (AW+1)'(BYTE_DEPTH);

   if (BYTE_DEPTH != (1 << AW)) begin : g_bad_depth
      $error("BYTE_DEPTH must be a power of two");
   end
   if (BYTE_DEPTH < 16 || BYTE_DEPTH > MAX_FRAME) begin : g_bad_range
      $error("BYTE_DEPTH must lie between 16 and the largest frame size");
   end
   if (MAX_PKTS < 2) begin : g_bad_pkts
      $error("MAX_PKTS must be at least 2");
   end

   // ---------------- storage ----------------
   logic            wr_en;
   logic [AW:0]     rd_adv;
   logic [7:0]      rd_lo, rd_hi;
   logic [AW:0]     used;
   logic            store_full;

   rxq_byte_store #(.DEPTH(BYTE_DEPTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (rx_reset),
      .wr_en   (wr_en),
      .wr_data (in_data),
      .rd_adv  (rd_adv),
      .rd_lo   (rd_lo),
      .rd_hi   (rd_hi),
      .used    (used)
   );

   assign store_full = (used == STORE_TOP);

   logic            q_push, q_pop;
   pkt_desc_t       q_in, q_head;
   logic [CW-1:0]   q_count;

   rxq_desc_queue #(.ENTRIES(MAX_PKTS), .W(DESC_W)) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (rx_reset),
      .push      (q_push),
      .push_data (q_in),
      .pop       (q_pop),
      .head      (q_head),
      .count     (q_count)
   );

   // ---------------- filter ----------------
   logic class_pass;

   rxq_class_filter u_filt (
      .accept_mask (filt_mask),
      .cls         (dest_class_t'(in_class)),
      .pass        (class_pass)
   );

   // ---------------- write side ----------------
   logic             in_frame, trunc;
   logic [LEN_W-1:0] cur_len;
   logic             sof_live, sof_wanted, start_ok;
   logic             stat_refuse, room_refuse;
   logic             cont_byte, hit_full, end_frame;
   logic [LEN_W-1:0] len_next;

   assign sof_live    = in_valid && in_sof && !rx_reset;
   assign sof_wanted  = sof_live && class_pass;
   assign stat_refuse = sof_wanted && (q_count == PKT_LIMIT);
   assign room_refuse = sof_wanted && (q_count != PKT_LIMIT) && (ovr_flag || store_full);
   assign start_ok    = sof_wanted && (q_count != PKT_LIMIT) && !ovr_flag && !store_full;

   assign cont_byte = in_valid && !in_sof && in_frame && !rx_reset;
   assign hit_full  = cont_byte && !trunc && store_full;
   assign wr_en     = start_ok || (cont_byte && !trunc && !store_full);
   assign end_frame = (start_ok || cont_byte) && in_eof;

   always_comb begin
      if (start_ok)   len_next = LEN_W'(1);
      else if (wr_en) len_next = cur_len + LEN_W'(1);
      else            len_next = cur_len;
   end

   assign q_push    = end_frame;
   assign q_in.len  = len_next;
   assign q_in.code = (cont_byte && (trunc || hit_full)) ? ERR_OVERRUN : err_code_t'(in_err);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame <= 1'b0;
         trunc    <= 1'b0;
         cur_len  <= '0;
      end else if (rx_reset) begin
         in_frame <= 1'b0;
         trunc    <= 1'b0;
         cur_len  <= '0;
      end else begin
         if (end_frame) begin
            in_frame <= 1'b0;
            trunc    <= 1'b0;
            cur_len  <= '0;
         end else if (start_ok) begin
            in_frame <= 1'b1;
            trunc    <= 1'b0;
            cur_len  <= len_next;
         end else if (cont_byte) begin
            trunc    <= trunc || hit_full;
            cur_len  <= len_next;
         end
      end
   end

   // ---------------- read side ----------------
   logic             have_pkt, have_byte;
   logic [LEN_W-1:0] consumed, head_rem;
   logic             two_left;
   logic             do_disc, do_rd, bad_rd;
   logic [7:0]       pad_val;

   assign have_pkt  = (q_count != '0);
   assign head_rem  = q_head.len - consumed;
   assign have_byte = have_pkt && (head_rem != '0);
   assign two_left  = (head_rem >= LEN_W'(2));

   assign do_disc = discard && have_pkt && !rx_reset;
   assign do_rd   = rd_word && !discard && have_byte && !rx_reset;
   assign bad_rd  = rd_word && !discard && !have_byte && !rx_reset;
   assign q_pop   = do_disc;

   always_comb begin
      if (do_disc)    rd_adv = head_rem[AW:0];
      else if (do_rd) rd_adv = two_left ? (AW+1)'(2) : (AW+1)'(1);
      else            rd_adv = '0;
   end

   if (PAD_REPEAT) begin : g_pad_repeat
      assign pad_val = rd_lo;
   end else begin : g_pad_const
      assign pad_val = PAD_BYTE;
   end

   assign rd_data = have_byte ? {(two_left ? rd_hi : pad_val), rd_lo} : 16'h0000;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   consumed <= '0;
      else if (rx_reset || do_disc) consumed <= '0;
      else if (do_rd)               consumed <= consumed + (two_left ? LEN_W'(2) : LEN_W'(1));
   end

   // ---------------- flags ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_flag      <= 1'b0;
         stat_ovr_flag <= 1'b0;
         underrun_flag <= 1'b0;
      end else if (rx_reset) begin
         ovr_flag      <= 1'b0;
         stat_ovr_flag <= 1'b0;
         underrun_flag <= 1'b0;
      end else begin
         if (hit_full || (room_refuse && store_full)) ovr_flag <= 1'b1;
         else if (rd_adv != '0)                       ovr_flag <= 1'b0;

         if (stat_refuse)  stat_ovr_flag <= 1'b1;
         else if (do_disc) stat_ovr_flag <= 1'b0;

         if (bad_rd) underrun_flag <= 1'b1;
      end
   end

   assign adapter_fail = underrun_flag;
   assign rx_complete  = have_pkt;
   assign status_word  = have_pkt ? {1'b0, q_head.code, head_rem}
                                  : {1'b1, 4'b0000, (in_frame ? cur_len : LEN_W'(0))};
endmodule

// File: rtl/rx_pkt_fifo_chk.sv
module rx_pkt_fifo_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        rx_reset,
   input logic        rd_word,
   input logic        discard,
   input logic [15:0] status_word,
   input logic        rx_complete,
   input logic        ovr_flag,
   input logic        stat_ovr_flag,
   input logic        underrun_flag
);
   // R1: without a complete packet the incomplete bit is raised
   a_r1_empty_bit: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_complete |-> status_word[15]);

   // R1: byte count never exceeds the largest frame
   a_r1_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
      status_word[10:0] <= 11'd1514);

   // R3: a full word read lowers the head count by two
   a_r3_word_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_word && !discard && !rx_reset && rx_complete && status_word[10:0] >= 11'd2)
      |=> (status_word[10:0] == $past(status_word[10:0]) - 11'd2));

   // R5: the status overrun flag implies queued packets
   a_r5_limit_full: assert property (@(posedge clk) disable iff (!rst_n)
      stat_ovr_flag |-> rx_complete);

   // R7: underrun stays set until receive reset
   a_r7_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (underrun_flag && !rx_reset) |=> underrun_flag);

   // R10: receive reset empties the block and clears the flags
   a_r10_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rx_reset |=> (!rx_complete && !ovr_flag && !stat_ovr_flag && !underrun_flag));
endmodule

bind rx_pkt_fifo rx_pkt_fifo_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rx_reset      (rx_reset),
   .rd_word       (rd_word),
   .discard       (discard),
   .status_word   (status_word),
   .rx_complete   (rx_complete),
   .ovr_flag      (ovr_flag),
   .stat_ovr_flag (stat_ovr_flag),
   .underrun_flag (underrun_flag)
);

// File: tb/sim_rx_pkt_fifo.sv
module sim_rx_pkt_fifo;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_reset = 1'b0;
   logic [3:0]  filt_mask = 4'hF;
   logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic [1:0]  in_class = 2'd0;
   logic [3:0]  in_err = 4'h0;
   logic        rd_word = 1'b0, discard = 1'b0;
   logic [15:0] rd_data, status_word;
   logic        rx_complete, ovr_flag, stat_ovr_flag, underrun_flag, adapter_fail;

   int n_chk = 0;
   int n_fail = 0;

   logic [7:0] exp_data[$];
   int         exp_len[$];
   logic [3:0] exp_code[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_pkt_fifo u0 (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [15:0] stat_of(input logic [3:0] code, input int len);
      return {1'b0, code, 11'(len)};
   endfunction

   function automatic logic class_ok(input logic [3:0] m, input logic [1:0] c);
      return m[3] || (c != 2'd3 && m[c]);
   endfunction

   task automatic send(input logic [1:0] cls, input int len, input logic [3:0] code,
                       input logic [7:0] seed, input bit finish);
      for (int i = 0; i < len; i++) begin
         in_valid = 1'b1;
         in_sof   = (i == 0);
         in_eof   = finish && (i == len - 1);
         in_data  = seed + 8'(i * 7);
         in_class = cls;
         in_err   = code;
         tick();
      end
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
   endtask

   task automatic end_byte(input logic [7:0] d, input logic [3:0] code);
      in_valid = 1'b1; in_eof = 1'b1; in_data = d; in_err = code;
      tick();
      in_valid = 1'b0; in_eof = 1'b0;
   endtask

   task automatic read_word(input string req, input logic [15:0] exp);
      rd_word = 1'b1;
      #1;
      check(req, rd_data, exp);
      tick();
      rd_word = 1'b0;
   endtask

   task automatic do_discard();
      discard = 1'b1;
      tick();
      discard = 1'b0;
   endtask

   task automatic pulse_rx_reset();
      rx_reset = 1'b1;
      tick();
      rx_reset = 1'b0;
   endtask

   task automatic random_round();
      int nfr = 1 + int'($urandom_range(5, 0));
      filt_mask = 4'($urandom_range(15, 0));
      for (int f = 0; f < nfr; f++) begin
         logic [1:0] cls = 2'($urandom_range(3, 0));
         int len = 1 + int'($urandom_range(23, 0));
         logic [3:0] code;
         logic [7:0] seed = 8'($urandom_range(255, 0));
         case ($urandom_range(3, 0))
            0: code = 4'b0000;
            1: code = 4'b1101;
            2: code = 4'b0010;
            default: code = 4'b1100;
         endcase
         if (class_ok(filt_mask, cls)) begin
            exp_len.push_back(len);
            exp_code.push_back(code);
            for (int i = 0; i < len; i++) exp_data.push_back(seed + 8'(i * 7));
         end
         send(cls, len, code, seed, 1'b1);
         repeat ($urandom_range(2, 0)) tick();
      end
      while (exp_len.size() != 0) begin
         int len = exp_len.pop_front();
         logic [3:0] code = exp_code.pop_front();
         check("R2 random status", status_word, stat_of(code, len));
         for (int i = 0; i < len; i += 2) begin
            logic [7:0] lo = exp_data.pop_front();
            logic [7:0] hi = (i + 1 < len) ? exp_data.pop_front() : 8'h00;
            read_word("R3 random data", {hi, lo});
         end
         check("R3 random drained", status_word[10:0], 11'd0);
         do_discard();
      end
      check("R8 R11 random empty", status_word, 16'h8000);
   endtask

   task automatic run_all();
      rst_n = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      check("R1 reset status", status_word, 16'h8000);
      check("R9 reset complete", rx_complete, 1'b0);
      check("R7 reset underrun", {underrun_flag, adapter_fail, ovr_flag, stat_ovr_flag}, 4'b0);

      filt_mask = 4'b1111;
      send(2'd0, 3, 4'h0, 8'h10, 1'b0);
      check("R1 in-progress status", status_word, 16'h8003);
      check("R9 in-progress complete", rx_complete, 1'b0);
      end_byte(8'hAB, 4'h0);
      check("R1 complete status", status_word, 16'h0004);
      check("R9 complete", rx_complete, 1'b1);
      read_word("R3 first word", {8'h17, 8'h10});
      check("R3 count after word", status_word, 16'h0002);
      read_word("R3 second word", {8'hAB, 8'h1E});
      check("R3 count zero", status_word, 16'h0000);
      rd_word = 1'b1; tick(); rd_word = 1'b0;
      check("R7 underrun set", {underrun_flag, adapter_fail}, 2'b11);
      check("R7 nothing consumed", status_word, 16'h0000);
      do_discard();
      check("R4 discard empties", status_word, 16'h8000);
      check("R7 underrun sticky", underrun_flag, 1'b1);
      pulse_rx_reset();
      check("R10 underrun cleared", {underrun_flag, adapter_fail}, 2'b00);

      send(2'd1, 5, 4'b1101, 8'h40, 1'b1);
      send(2'd2, 3, 4'b0010, 8'h60, 1'b1);
      check("R2 crc code", status_word, 16'h6805);
      read_word("R3 crc packet word", {8'h47, 8'h40});
      do_discard();
      check("R4 next status dribble", status_word, 16'h1003);
      read_word("R3 word", {8'h67, 8'h60});
      read_word("R3 odd pad", {8'h00, 8'h6E});
      do_discard();
      do_discard();
      check("R4 discard no effect", status_word, 16'h8000);
      rd_word = 1'b1; tick(); rd_word = 1'b0;
      check("R7 empty read underrun", underrun_flag, 1'b1);
      pulse_rx_reset();

      filt_mask = 4'b0001;
      send(2'd2, 4, 4'h0, 8'h00, 1'b1);
      check("R11 broadcast refused", {rx_complete, status_word}, {1'b0, 16'h8000});
      send(2'd3, 4, 4'h0, 8'h00, 1'b1);
      check("R8 other refused", rx_complete, 1'b0);
      send(2'd0, 2, 4'h0, 8'h20, 1'b1);
      check("R8 station accepted", status_word, 16'h0002);
      filt_mask = 4'b1000;
      send(2'd3, 6, 4'h0, 8'h30, 1'b1);
      do_discard();
      check("R8 promiscuous accepted", status_word, 16'h0006);
      pulse_rx_reset();
      check("R10 queue emptied", {rx_complete, status_word}, {1'b0, 16'h8000});

      filt_mask = 4'b0001;
      for (int p = 0; p < 8; p++) send(2'd0, 2, 4'h0, 8'(p), 1'b1);
      check("R5 eight queued no flag", stat_ovr_flag, 1'b0);
      send(2'd0, 3, 4'h0, 8'h90, 1'b1);
      check("R5 ninth refused flag", stat_ovr_flag, 1'b1);
      do_discard();
      check("R5 flag clears on discard", stat_ovr_flag, 1'b0);
      for (int p = 0; p < 7; p++) do_discard();
      check("R5 ninth not stored", {rx_complete, status_word}, {1'b0, 16'h8000});

      filt_mask = 4'b1111;
      send(2'd0, 200, 4'h0, 8'h01, 1'b1);
      send(2'd0, 100, 4'h0, 8'h02, 1'b1);
      check("R6 overrun set", ovr_flag, 1'b1);
      send(2'd0, 4, 4'h0, 8'h03, 1'b1);
      read_word("R3 data before clear", {8'h08, 8'h01});
      check("R6 overrun cleared by read", ovr_flag, 1'b0);
      check("R6 first status", status_word, 16'h00C6);
      do_discard();
      check("R6 truncated packet", status_word, 16'h4038);
      do_discard();
      check("R6 refused frame absent", {rx_complete, status_word}, {1'b0, 16'h8000});

      send(2'd0, 5, 4'h0, 8'h50, 1'b1);
      send(2'd0, 3, 4'h0, 8'h58, 1'b0);
      pulse_rx_reset();
      check("R10 mid-frame reset", {rx_complete, status_word}, {1'b0, 16'h8000});
      end_byte(8'h77, 4'h0);
      check("R10 tail ignored", status_word, 16'h8000);

      for (int r = 0; r < 40; r++) random_round();
   endtask

   initial begin
      void'($urandom(32'd20240611));
      fork
         run_all();
         begin
            repeat (WATCHDOG) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      disable fork;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule